// File: doc/BRIEF.md
# Serial EEPROM Station-Address Loader

This block fetches the full contents of a small four-wire serial EEPROM (select, clock, data toward the memory, data from the memory) after a one-cycle start request. The memory is organised as 16-bit words. For every word the block sends a read command carrying that word's index and shifts in sixteen data bits, which it stores as two bytes in an internal image. The words are fetched in ascending order, and the image is complete after the last word.

Once the image is complete, the block XORs a parameterised range of bytes and compares the result with a checksum byte held at a parameterised offset. If the two agree, it presents a six-byte station address taken from a third parameterised offset and raises an address-valid flag. If they disagree, it raises a checksum-error flag and the address stays zero. The serial clock half-period is a parameter counted in system clock cycles.

The controller is one state machine with these states: `ST_IDLE` (waiting for start), `ST_DESEL` (select low for one half-period before each word), `ST_CMD_LO` / `ST_CMD_HI` (low and high clock phases of each command bit), `ST_TURN` (select high with the clock low, the dummy status slot), `ST_DAT_HI` / `ST_DAT_LO` (high and low clock phases of each data bit), `ST_REST` (all lines low after a word), `ST_CHECK` (one cycle to compare the checksum) and `ST_FIN` (one cycle that reports completion). Its transitions are:

- IDLE→DESEL when start is seen.
- DESEL→CMD_LO after one half-period.
- CMD_LO→CMD_HI after each half-period.
- CMD_HI→CMD_LO while command bits remain, and CMD_HI→TURN after the last one.
- TURN→DAT_HI after one half-period.
- DAT_HI→DAT_LO after each half-period.
- DAT_LO→DAT_HI while data bits remain, and DAT_LO→REST after the sixteenth.
- REST→DESEL for the next word, and REST→CHECK after the last word.
- CHECK→FIN, then FIN→IDLE.

Top module: `eeprom_addr_reader`

## Requirements
- R1: After reset, cs_o, sclk_o, mosi_o, busy_o, done_o, addr_ok_o and sum_bad_o are all 0, and station_addr_o is zero.
- R2: Before each word access, cs_o is low for at least HALF_CYC system cycles before it rises. While cs_o is low, sclk_o and mosi_o are low.
- R3: The command for each word is 10 bits in this order: 0, 1, 1, 0, then the 6-bit word index with the most significant bit first. Each bit is placed on mosi_o while sclk_o is low and held through the high phase. Word indices run 0 to NWORDS-1 in ascending order.
- R4: Each serial clock phase lasts HALF_CYC system cycles, so successive rising edges of sclk_o within one access are 2*HALF_CYC cycles apart.
- R5: After the command comes one low-clock turnaround phase. Then 16 data bits are taken from miso_i, most significant first, one bit per rising sclk_o edge, each sampled during the following low phase. The first 8 bits of word w form byte 2w and the last 8 bits form byte 2w+1.
- R6: The block XORs the bytes at offsets KEY_OFS up to SUM_OFS-1. If the result equals the byte at SUM_OFS, addr_ok_o=1 and sum_bad_o=0. Bytes outside this range do not affect the outcome.
- R7: If the checksum does not match, sum_bad_o=1, addr_ok_o=0 and station_addr_o stays zero.
- R8: When the checksum matches, station_addr_o[47-8i -: 8] equals the byte at ADDR_OFS+i for i = 0..5.
- R9: done_o pulses for exactly one cycle per load, in the same cycle the result flags take their new values. The flags and the address hold until the next accepted start, which clears them.
- R10: A start request while busy_o=1 is ignored. The current load continues with the next word index and produces exactly one done_o pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | One-cycle request to load the EEPROM |
| busy_o | output | 1 | Load in progress |
| done_o | output | 1 | One-cycle completion pulse |
| cs_o | output | 1 | EEPROM chip select |
| sclk_o | output | 1 | EEPROM serial clock |
| mosi_o | output | 1 | Serial data toward the EEPROM |
| miso_i | input | 1 | Serial data from the EEPROM |
| addr_ok_o | output | 1 | Checksum matched; address valid |
| sum_bad_o | output | 1 | Checksum mismatch |
| station_addr_o | output | 48 | Six-byte station address, first byte in the top bits |

## Verification
The bench builds the block with HALF_CYC=2, KEY_OFS=1, SUM_OFS=15 and ADDR_OFS=16. The short half-period makes a full 16-word load take under two thousand cycles, so several images fit in one run. Moving the key offset off zero leaves byte 0 outside the checksum range, which lets the bench show that changing a byte below the range, or an address byte above it, leaves the result valid. The images include an all-0xFF image, whose even number of summed 0xFF bytes XORs to zero and so mismatches the stored 0xFF.

// File: rtl/mw_pkg.sv
package mw_pkg;
    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DESEL,
        ST_CMD_LO,
        ST_CMD_HI,
        ST_TURN,
        ST_DAT_HI,
        ST_DAT_LO,
        ST_REST,
        ST_CHECK,
        ST_FIN
    } mw_state_t;

    localparam int unsigned MW_WORD_BITS = 16;
    localparam int unsigned MW_HDR_BITS  = 4;
    localparam logic [3:0]  MW_HDR       = 4'b0110; // dummy 0, start 1, read opcode 1 0
    localparam int unsigned MW_ADDR_BYTES = 6;
endpackage

// File: rtl/mw_half_timer.sv
module mw_half_timer #(
    parameter int unsigned HALF_CYC = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int unsigned CW = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
    localparam logic [CW-1:0] LAST = CW'(HALF_CYC - 1);

    logic [CW-1:0] cnt_q;

    assign tick = run && (cnt_q == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run || tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/mw_seq.sv
module mw_seq
    import mw_pkg::*;
#(
    parameter int unsigned NWORDS = 16,
    parameter int unsigned ABITS  = 6,
    localparam int unsigned WW    = (NWORDS > 1) ? $clog2(NWORDS) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          tick,
    input  logic          miso,
    output logic          cs,
    output logic          sk,
    output logic          di,
    output logic          busy,
    output logic          done,
    output logic          chk_en,
    output logic          wr_en,
    output logic [WW-1:0] wr_idx,
    output logic [15:0]   wr_data
);
    localparam int unsigned CMD_LEN = MW_HDR_BITS + ABITS;
    localparam int unsigned CNT_MAX = (CMD_LEN > MW_WORD_BITS) ? CMD_LEN : MW_WORD_BITS;
    localparam int unsigned CW      = $clog2(CNT_MAX);
    localparam logic [WW-1:0] LAST_WORD = WW'(NWORDS - 1);

    mw_state_t          state_q, state_d;
    logic [CW-1:0]      bcnt_q;
    logic [WW-1:0]      widx_q;
    logic [CMD_LEN-1:0] cmd_q;
    logic [15:0]        shin_q;

    // next-state decision
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start) state_d = ST_DESEL;
            ST_DESEL:  if (tick)  state_d = ST_CMD_LO;
            ST_CMD_LO: if (tick)  state_d = ST_CMD_HI;
            ST_CMD_HI: if (tick)  state_d = (bcnt_q == '0) ? ST_TURN : ST_CMD_LO;
            ST_TURN:   if (tick)  state_d = ST_DAT_HI;
            ST_DAT_HI: if (tick)  state_d = ST_DAT_LO;
            ST_DAT_LO: if (tick)  state_d = (bcnt_q == '0) ? ST_REST : ST_DAT_HI;
            ST_REST:   if (tick)  state_d = (widx_q == LAST_WORD) ? ST_CHECK : ST_DESEL;
            ST_CHECK:             state_d = ST_FIN;
            ST_FIN:               state_d = ST_IDLE;
            default:              state_d = ST_IDLE;
        endcase
    end

    // state register and its counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            bcnt_q  <= '0;
            widx_q  <= '0;
            cmd_q   <= '0;
            shin_q  <= '0;
        end else begin
            state_q <= state_d;
            unique case (state_q)
                ST_IDLE: if (start) widx_q <= '0;
                ST_DESEL: if (tick) begin
                    bcnt_q <= CW'(CMD_LEN - 1);
                    cmd_q  <= {MW_HDR, ABITS'(widx_q)};
                end
                ST_CMD_HI: if (tick && bcnt_q != '0) begin
                    bcnt_q <= bcnt_q - 1'b1;
                    cmd_q  <= {cmd_q[CMD_LEN-2:0], 1'b0};
                end
                ST_TURN: if (tick) bcnt_q <= CW'(MW_WORD_BITS - 1);
                ST_DAT_LO: if (tick) begin
                    shin_q <= {shin_q[14:0], miso};
                    if (bcnt_q != '0) bcnt_q <= bcnt_q - 1'b1;
                end
                ST_REST: if (tick) widx_q <= widx_q + 1'b1;
                default: ;
            endcase
        end
    end

    // outputs decoded from the registered state
    always_comb begin
        cs      = 1'b0;
        sk      = 1'b0;
        di      = 1'b0;
        busy    = (state_q != ST_IDLE);
        done    = 1'b0;
        chk_en  = 1'b0;
        wr_en   = 1'b0;
        wr_idx  = widx_q;
        wr_data = {shin_q[14:0], miso};
        unique case (state_q)
            ST_CMD_LO: begin cs = 1'b1; di = cmd_q[CMD_LEN-1]; end
            ST_CMD_HI: begin cs = 1'b1; sk = 1'b1; di = cmd_q[CMD_LEN-1]; end
            ST_TURN:   cs = 1'b1;
            ST_DAT_HI: begin cs = 1'b1; sk = 1'b1; end
            ST_DAT_LO: begin cs = 1'b1; wr_en = tick && (bcnt_q == '0); end
            ST_CHECK:  chk_en = 1'b1;
            ST_FIN:    done = 1'b1;
            default: ;
        endcase
    end
endmodule

// File: rtl/mw_image.sv
module mw_image
    import mw_pkg::*;
#(
    parameter int unsigned NWORDS   = 16,
    parameter int unsigned KEY_OFS  = 0,
    parameter int unsigned SUM_OFS  = 15,
    parameter int unsigned ADDR_OFS = 16,
    localparam int unsigned WW      = (NWORDS > 1) ? $clog2(NWORDS) : 1,
    localparam int unsigned NBYTES  = 2 * NWORDS
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          wr_en,
    input  logic [WW-1:0] wr_idx,
    input  logic [15:0]   wr_data,
    input  logic          chk_en,
    output logic          ok,
    output logic          bad,
    output logic [47:0]   addr
);
    logic [7:0]  img_q [NBYTES];
    logic [7:0]  acc;
    logic [47:0] cand;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NBYTES; i++) img_q[i] <= '0;
        end else if (wr_en) begin
            for (int i = 0; i < NWORDS; i++) begin
                if (wr_idx == WW'(i)) begin
                    img_q[2*i]   <= wr_data[15:8];
                    img_q[2*i+1] <= wr_data[7:0];
                end
            end
        end
    end

    always_comb begin
        acc = '0;
        for (int i = KEY_OFS; i < SUM_OFS; i++) acc = acc ^ img_q[i];
    end

    for (genvar g = 0; g < MW_ADDR_BYTES; g++) begin : g_addr
        assign cand[47-8*g -: 8] = img_q[ADDR_OFS+g];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ok   <= 1'b0;
            bad  <= 1'b0;
            addr <= '0;
        end else if (clr) begin
            ok   <= 1'b0;
            bad  <= 1'b0;
            addr <= '0;
        end else if (chk_en) begin
            ok   <= (acc == img_q[SUM_OFS]);
            bad  <= (acc != img_q[SUM_OFS]);
            addr <= (acc == img_q[SUM_OFS]) ? cand : 48'd0;
        end
    end
endmodule

// File: rtl/eeprom_addr_reader.sv
module eeprom_addr_reader #(
    parameter int unsigned HALF_CYC = 4,
    parameter int unsigned NWORDS   = 16,
    parameter int unsigned ABITS    = 6,
    parameter int unsigned KEY_OFS  = 0,
    parameter int unsigned SUM_OFS  = 15,
    parameter int unsigned ADDR_OFS = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start_i,
    output logic        busy_o,
    output logic        done_o,
    output logic        cs_o,
    output logic        sclk_o,
    output logic        mosi_o,
    input  logic        miso_i,
    output logic        addr_ok_o,
    output logic        sum_bad_o,
    output logic [47:0] station_addr_o
);
    localparam int unsigned WW = (NWORDS > 1) ? $clog2(NWORDS) : 1;

    logic          tick, chk_en, wr_en;
    logic [WW-1:0] wr_idx;
    logic [15:0]   wr_data;

    mw_half_timer #(.HALF_CYC(HALF_CYC)) u_timer (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (busy_o),
        .tick (tick)
    );

    mw_seq #(.NWORDS(NWORDS), .ABITS(ABITS)) u_seq (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (start_i),
        .tick   (tick),
        .miso   (miso_i),
        .cs     (cs_o),
        .sk     (sclk_o),
        .di     (mosi_o),
        .busy   (busy_o),
        .done   (done_o),
        .chk_en (chk_en),
        .wr_en  (wr_en),
        .wr_idx (wr_idx),
        .wr_data(wr_data)
    );

    mw_image #(
        .NWORDS(NWORDS), .KEY_OFS(KEY_OFS), .SUM_OFS(SUM_OFS), .ADDR_OFS(ADDR_OFS)
    ) u_image (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (start_i && !busy_o),
        .wr_en  (wr_en),
        .wr_idx (wr_idx),
        .wr_data(wr_data),
        .chk_en (chk_en),
        .ok     (addr_ok_o),
        .bad    (sum_bad_o),
        .addr   (station_addr_o)
    );
endmodule

// File: rtl/mw_reader_chk.sv
module mw_reader_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        start_i,
    input logic        busy_o,
    input logic        done_o,
    input logic        cs_o,
    input logic        sclk_o,
    input logic        mosi_o,
    input logic        addr_ok_o,
    input logic        sum_bad_o,
    input logic [47:0] station_addr_o
);
    assert_idle_deselected_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> !cs_o);

    assert_lines_low_deselected_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_o |-> (!sclk_o && !mosi_o));

    assert_data_held_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk_o && $past(sclk_o)) |-> $stable(mosi_o));

    assert_ok_at_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(addr_ok_o) |-> done_o);

    assert_flags_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(addr_ok_o && sum_bad_o));

    assert_bad_at_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sum_bad_o) |-> done_o);

    assert_addr_gated_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !addr_ok_o |-> (station_addr_o == 48'd0));

    assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    assert_busy_kept_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i && !done_o) |=> busy_o);
endmodule

bind eeprom_addr_reader mw_reader_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .start_i       (start_i),
    .busy_o        (busy_o),
    .done_o        (done_o),
    .cs_o          (cs_o),
    .sclk_o        (sclk_o),
    .mosi_o        (mosi_o),
    .addr_ok_o     (addr_ok_o),
    .sum_bad_o     (sum_bad_o),
    .station_addr_o(station_addr_o)
);

// File: tb/test_eeprom_addr_reader.sv
module test_eeprom_addr_reader;
    localparam int CLK_PERIOD = 10;
    localparam int HALF  = 2;
    localparam int NW    = 16;
    localparam int NB    = 2 * NW;
    localparam int KEY   = 1;
    localparam int SUM   = 15;
    localparam int AOFS  = 16;
    localparam int WDOG  = 150000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic        busy_o, done_o, cs_o, sclk_o, mosi_o;
    logic        miso_i = 1'b0;
    logic        addr_ok_o, sum_bad_o;
    logic [47:0] station_addr_o;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    int done_cnt = 0;

    logic [7:0] img [NB];

    typedef struct packed {
        logic        ok;
        logic        bad;
        logic [47:0] addr;
    } exp_t;
    exp_t sb[$];

    eeprom_addr_reader #(
        .HALF_CYC(HALF), .NWORDS(NW), .ABITS(6),
        .KEY_OFS(KEY), .SUM_OFS(SUM), .ADDR_OFS(AOFS)
    ) i_eeprom_addr_reader (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .busy_o(busy_o),
        .done_o(done_o), .cs_o(cs_o), .sclk_o(sclk_o), .mosi_o(mosi_o),
        .miso_i(miso_i), .addr_ok_o(addr_ok_o), .sum_bad_o(sum_bad_o),
        .station_addr_o(station_addr_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input bit cond, input string req, input logic [63:0] act,
                         input logic [63:0] exp);
        n_chk++;
        if (!cond) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > WDOG) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual %0d expected <= %0d cycles", cyc, WDOG);
            finish_run();
        end
    end

    // behavioural EEPROM responder and serial-line checker
    int         resp_word = 0;
    int         edge_n = 0;
    int         low_cnt = 0;
    int         last_rise = 0;
    logic [9:0] cmd_cap = '0;
    logic       cs_d = 1'b0;
    logic       sk_d = 1'b0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (cs_o && !cs_d) begin
                // R2: select low for at least one half-period before rising
                check(low_cnt >= HALF, "R2 select low time", low_cnt, HALF);
                edge_n = 0;
            end
            if (!cs_o && cs_d) begin
                miso_i = 1'b0;
                resp_word++;
            end
            if (cs_o && sclk_o && !sk_d) begin
                edge_n++;
                if (edge_n >= 2)
                    check((cyc - last_rise) == 2 * HALF, "R4 clock period",
                          cyc - last_rise, 2 * HALF);
                last_rise = cyc;
                if (edge_n <= 10) cmd_cap = {cmd_cap[8:0], mosi_o};
                if (edge_n == 10)
                    check(cmd_cap == {4'b0110, 6'(resp_word)}, "R3 command and index",
                          cmd_cap, {4'b0110, 6'(resp_word)});
                if (edge_n >= 11 && edge_n <= 26) begin
                    logic [15:0] w;
                    w = {img[2*resp_word], img[2*resp_word+1]};
                    miso_i = w[15 - (edge_n - 11)];
                end
            end
            low_cnt = cs_o ? 0 : low_cnt + 1;
        end
        cs_d = cs_o;
        sk_d = sclk_o;
    end

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && done_o) begin
            done_cnt++;
            if (sb.size() == 0) begin
                check(1'b0, "R9 unexpected done", 1, 0);
            end else begin
                exp_t e;
                exp_t a;
                e = sb.pop_front();
                a = {addr_ok_o, sum_bad_o, station_addr_o};
                check(a.ok == e.ok, "R6 valid flag", a.ok, e.ok);
                check(a.bad == e.bad, "R7 mismatch flag", a.bad, e.bad);
                check(a.addr == e.addr, "R8/R5 station address", a.addr, e.addr);
            end
        end
    end

    task automatic fix_sum();
        logic [7:0] x;
        x = '0;
        for (int i = KEY; i < SUM; i++) x ^= img[i];
        img[SUM] = x;
    endtask

    task automatic run_read(input bit poke_mid);
        exp_t e;
        logic [7:0] x;
        int d0;
        x = '0;
        for (int i = KEY; i < SUM; i++) x ^= img[i];
        e.ok  = (x == img[SUM]);
        e.bad = (x != img[SUM]);
        e.addr = '0;
        if (e.ok)
            for (int i = 0; i < 6; i++) e.addr[47-8*i -: 8] = img[AOFS+i];
        sb.push_back(e);
        resp_word = 0;
        d0 = done_cnt;
        @(negedge clk) start_i = 1'b1;
        @(negedge clk) start_i = 1'b0;
        // R9: accepted start clears the previous result
        check(busy_o && !addr_ok_o && !sum_bad_o && station_addr_o == 0,
              "R9 clear on start", {busy_o, addr_ok_o, sum_bad_o}, 3'b100);
        if (poke_mid) begin
            repeat (300) @(negedge clk);
            start_i = 1'b1;              // R10: must be ignored
            @(negedge clk) start_i = 1'b0;
        end
        while (busy_o) @(negedge clk);
        check(done_cnt == d0 + 1, "R9/R10 one done per load", done_cnt - d0, 1);
        check(resp_word == NW, "R3 words fetched", resp_word, NW);
        repeat (5) @(negedge clk);
        check({addr_ok_o, sum_bad_o} == {e.ok, e.bad}, "R9 flags hold",
              {addr_ok_o, sum_bad_o}, {e.ok, e.bad});
    endtask

    initial begin
        for (int i = 0; i < NB; i++) img[i] = 8'(i * 37 + 5);
        repeat (3) @(negedge clk);
        // R1: reset state
        check({cs_o, sclk_o, mosi_o, busy_o, done_o, addr_ok_o, sum_bad_o} == 0,
              "R1 reset outputs", {cs_o, sclk_o, mosi_o, busy_o, done_o, addr_ok_o, sum_bad_o}, 0);
        check(station_addr_o == 0, "R1 reset address", station_addr_o, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        fix_sum();
        run_read(1'b0);                 // R5/R6/R8 distinct bytes, matching sum
        img[SUM] ^= 8'h01;
        run_read(1'b0);                 // R7 mismatch
        img[SUM] ^= 8'h01;
        img[0] = 8'hA5;                 // R6 byte below key range
        img[AOFS+2] = 8'h3C;            // R6 address byte outside range
        run_read(1'b0);
        for (int i = 0; i < NB; i++) img[i] = 8'h00;
        run_read(1'b0);                 // R6 all zero: valid, zero address
        for (int i = 0; i < NB; i++) img[i] = 8'hFF;
        run_read(1'b0);                 // R7 all ones: even count XORs to 0
        for (int i = 0; i < NB; i++) img[i] = 8'(255 - i * 11);
        fix_sum();
        run_read(1'b1);                 // R10 start while busy
        check(sb.size() == 0, "R9 scoreboard drained", sb.size(), 0);
        finish_run();
    end
endmodule